// File: doc/BRIEF.md
# Fully Associative Tag Store with First-In-First-Out Replacement

This block is a small content-addressable store. Each entry holds a full address as its tag, a data word and a valid flag. The incoming address is compared with every valid tag at the same time. When a tag equals the address, that entry's word line is raised. The word line selects the entry that drives the read data and the entry that takes a write. No address decoder is involved. When no word line is raised, the miss output goes high.

Writes are applied on the clock edge. A write that hits replaces only the data word of the matching entry. A write that misses installs both tag and data in the entry chosen by an internal victim pointer, and the pointer then steps to the next entry. The pointer moves only on these installs, so the entries are replaced oldest first. A single-cycle flush input clears every valid flag.

The ports are plain level signals with no handshake. Reads are combinational, and every write completes in one cycle, so there is no back-pressure to manage.

Top module: `cam_fifo_assoc`

## Requirements
- R1: While reset is held, and after it is released, every entry is invalid and every address misses, address 0 included. The victim pointer starts at entry 0.
- R2: `miss` is high exactly when no valid entry has a tag equal to `addr`, in the same cycle as `addr` is applied.
- R3: When `miss` is low, `rdata` equals the data word of the matching entry in the same cycle, with no clock edge in between.
- R4: A write (`wr_en` high, `flush` low) that hits changes only the data word of the matching entry. The tag, the other entries and the victim pointer are unchanged.
- R5: A write that misses stores `addr` as the tag, `wdata` as the data and sets the valid flag in the entry selected by the victim pointer. The result is visible from the next cycle.
- R6: The victim pointer advances by one on each write that misses and wraps from ENTRIES-1 to 0. After ENTRIES+1 writes to distinct addresses, the first address written misses and the others hit.
- R7: A cycle with `flush` high clears every valid flag, so from the next cycle every address misses. A write in that same cycle is ignored.
- R8: At most one entry matches any address at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and flush are taken on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Lookup and write address |
| wdata | input | DATA_W | Data to be written |
| wr_en | input | 1 | Write strobe for the current cycle |
| flush | input | 1 | Invalidate all entries |
| rdata | output | DATA_W | Data of the matching entry; zero on a miss |
| miss | output | 1 | High when no valid entry matches `addr` |

## Verification
The assertions assume that `addr`, `wdata`, `wr_en` and `flush` change only between clock edges and are never unknown outside reset. The write-visibility property also assumes that a repeated address in the following cycle is a read-back of the same location. The stimulus meets both conditions: it changes inputs shortly after each rising edge, holds strobes low during reset, and reads each location back only after its write edge. Because it never writes an address that is already present through the miss path, the single-match property is also exercised across the whole run.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_FILL   = 2'd1,
    OP_UPDATE = 2'd2,
    OP_FLUSH  = 2'd3
  } cam_op_e;
endpackage

// File: rtl/cam_match.sv
module cam_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16
) (
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q,
  input  logic [ENTRIES-1:0]             valid_q,
  input  logic [ADDR_W-1:0]              addr,
  output logic [ENTRIES-1:0]             word_line
);
  // one comparator per entry stands in for the address decoder
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign word_line[i] = valid_q[i] && (tag_q[i] == addr);
  end
endmodule

// File: rtl/cam_rowptr.sv
module cam_rowptr #(
  parameter int ENTRIES = 4,
  localparam int PW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R6: step by one with wrap on each install
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));
  // R4: pointer holds when nothing is installed
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/cam_store.sv
module cam_store
  import cam_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  localparam int PW     = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  cam_op_e                        op,
  input  logic [PW-1:0]                  ptr,
  input  logic [ENTRIES-1:0]             word_line,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [ENTRIES-1:0][ADDR_W-1:0] tag_q,
  output logic [ENTRIES-1:0][DATA_W-1:0] data_q,
  output logic [ENTRIES-1:0]             valid_q
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic fill_sel, upd_sel;
    assign fill_sel = (op == OP_FILL) && (ptr == PW'(i));
    assign upd_sel  = (op == OP_UPDATE) && word_line[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        data_q[i]  <= '0;
      end else if (op == OP_FLUSH) begin
        valid_q[i] <= 1'b0;
      end else if (fill_sel) begin
        valid_q[i] <= 1'b1;
        tag_q[i]   <= addr;
        data_q[i]  <= wdata;
      end else if (upd_sel) begin
        data_q[i]  <= wdata;
      end
    end

    // R4: a data update leaves the tag of that entry untouched
    a_r4_tag_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_UPDATE) |=> $stable(tag_q[i]));
  end
endmodule

// File: rtl/cam_fifo_assoc.sv
module cam_fifo_assoc
  import cam_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              flush,
  output logic [DATA_W-1:0] rdata,
  output logic              miss
);
  localparam int PW = $clog2(ENTRIES);

  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q;
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0]             word_line;
  logic [PW-1:0]                  ptr;
  cam_op_e                        op;

  cam_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .tag_q(tag_q), .valid_q(valid_q), .addr(addr), .word_line(word_line)
  );

  assign miss = ~|word_line;

  always_comb begin
    if (flush)      op = OP_FLUSH;
    else if (!wr_en) op = OP_IDLE;
    else if (miss)  op = OP_FILL;
    else            op = OP_UPDATE;
  end

  cam_rowptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(op == OP_FILL), .ptr(ptr)
  );

  cam_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .op(op), .ptr(ptr), .word_line(word_line),
    .addr(addr), .wdata(wdata), .tag_q(tag_q), .data_q(data_q), .valid_q(valid_q)
  );

  // word lines gate the data array onto the read bus
  always_comb begin
    rdata = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (word_line[i]) rdata = rdata | data_q[i];
  end

  // R8: never more than one word line
  a_r8_one_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_line));
  // R5: a write is readable at the same address in the next cycle
  a_r5_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> (addr != $past(addr)) || (!miss && rdata == $past(wdata)));
  // R7: everything misses after a flush
  a_r7_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> miss);
endmodule

// File: tb/sim_cam_fifo_assoc.sv
module sim_cam_fifo_assoc;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr_en = 1'b0;
  logic          flush = 1'b0;
  logic [DW-1:0] rdata;
  logic          miss;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_fifo_assoc #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .flush(flush), .rdata(rdata), .miss(miss)
  );

  // reference model built from the requirements
  logic [AW-1:0] m_tag [N];
  logic [DW-1:0] m_dat [N];
  logic          m_vld [N];
  int            m_ptr;

  typedef struct { logic [AW-1:0] a; logic m; logic [DW-1:0] d; string req; } exp_t;
  exp_t sb[$];

  task automatic model_look(input logic [AW-1:0] a, output logic m, output logic [DW-1:0] d);
    m = 1'b1; d = '0;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_tag[i] == a) begin m = 1'b0; d = m_dat[i]; end
  endtask

  task automatic probe(input logic [AW-1:0] a, input string req);
    exp_t e;
    @(posedge clk); #1;
    wr_en = 1'b0; flush = 1'b0; addr = a;
    e.a = a; e.req = req;
    model_look(a, e.m, e.d);
    sb.push_back(e);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic m; logic [DW-1:0] x;
    @(posedge clk); #1;
    flush = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    model_look(a, m, x);
    if (!m) begin
      for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == a) m_dat[i] = d;
    end else begin
      m_tag[m_ptr] = a; m_dat[m_ptr] = d; m_vld[m_ptr] = 1'b1;
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  task automatic flush_with_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    flush = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (miss !== e.m || (!e.m && rdata !== e.d)) begin
        bad++;
        $display("FAIL %s addr=%h: miss=%b rdata=%h expected miss=%b rdata=%h",
                 e.req, e.a, miss, rdata, e.m, e.d);
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; m_dat[i] = '0; end
    m_ptr = 0;
    repeat (3) @(posedge clk);
    // R1: misses while reset is held (address 0 equals the reset tag value)
    #1; addr = '0;
    @(negedge clk);
    total++;
    if (miss !== 1'b1) begin bad++; $display("FAIL R1 in reset: miss=%b expected 1", miss); end
    @(posedge clk); #1; rst_n = 1'b1;
    probe(16'h0000, "R1");
    probe(16'h1234, "R1");
    // R5 install, R3 same-cycle read, R2 neighbour address misses
    wr(16'h0010, 16'hAAAA);
    probe(16'h0010, "R5");
    probe(16'h0011, "R2");
    wr(16'h0020, 16'hBBBB);
    wr(16'h0030, 16'hCCCC);
    wr(16'h0040, 16'hDDDD);
    probe(16'h0020, "R3");
    probe(16'h0030, "R3");
    probe(16'h0040, "R3");
    // R4 update hit keeps others and pointer
    wr(16'h0010, 16'h5555);
    probe(16'h0010, "R4");
    probe(16'h0020, "R4");
    // R6: next install evicts the oldest entry, since the hit did not move the pointer
    wr(16'h0050, 16'hEEEE);
    probe(16'h0010, "R6");
    probe(16'h0050, "R6");
    probe(16'h0020, "R6");
    wr(16'h0060, 16'hF0F0);
    probe(16'h0020, "R6");
    probe(16'h0060, "R8");
    // R7 flush with a write in the same cycle
    flush_with_write(16'h0070, 16'h7777);
    probe(16'h0070, "R7");
    probe(16'h0030, "R7");
    probe(16'h0050, "R7");
    probe(16'h0060, "R7");
    // R6: ENTRIES+1 distinct writes evict the first
    for (int k = 0; k <= N; k++) wr(16'h0100 + AW'(k), 16'h9000 + DW'(k));
    for (int k = 0; k <= N; k++) probe(16'h0100 + AW'(k), "R6");
    // R8: rewrite an existing address, single match gives newest data
    wr(16'h0102, 16'h1212);
    probe(16'h0102, "R8");
    probe(16'h0103, "R2");
    @(posedge clk); #1; wr_en = 1'b0;
    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule